// File: doc/BRIEF.md
# Mark-Space Modulator with End-of-Cycle Flag

This block produces a repeating output pattern made of a high "mark" interval followed by a low "space" interval. Software programs a 16-bit mark count and a 16-bit space count through a small byte-wide register port, then sets a run bit. A down-counter takes the mark count and a space holding register takes the space count. The output stays high while the mark counter runs and low while the space count runs out. At every cycle boundary both are reloaded from the programmed registers, so new values written during a cycle take effect at the next boundary.

An end-of-cycle flag is raised when the modulator starts from idle and at every reload while the run bit is set. With the request-enable bit set, the flag drives either an interrupt line or a DMA request line, chosen by a mode bit. In interrupt mode the flag is cleared by a status read that sees the flag set, followed by an access to the mark-low or space-low byte. In DMA mode it is cleared by a transfer-done pulse.

Top module: `mark_space_mod`

## Requirements
- R1: After reset, mod_out, irq and dma_req are 0, every register reads 0 and the flag is clear.
- R2: When the modulator is idle and the run bit (control bit 0) is 1, the next clock edge starts a cycle and sets the flag. mod_out is then high for M+1 clocks and low for S+1 clocks, where M = {addr0, addr1} and S = {addr2, addr3}.
- R3: At each cycle boundary with the run bit set, the flag is set and the next cycle starts at once with the current register values. This happens whether or not the flag was cleared.
- R4: If the run bit is 0 at a cycle boundary, the cycle still runs to its end, no flag is set there, and mod_out stays low afterwards.
- R5: If the run bit is cleared and set again within a cycle, nothing happens at the re-set. The cycle continues unchanged and the flag is set at its boundary.
- R6: irq = flag AND request-enable (control bit 1) AND NOT DMA mode (control bit 2). dma_req = flag AND request-enable AND DMA mode.
- R7: In interrupt mode, a read of address 4 that sees the flag set arms a clear. The next access (read or write) to address 1 or 3 clears the flag. Any other access in between disarms the clear.
- R8: In DMA mode, a dma_done pulse clears the flag and the register-access sequence does not.
- R9: Writes to the mark and space bytes do not change the running cycle. They apply from the next boundary.
- R10: A flag set and a clear on the same clock edge leave the flag set.
- R11: The registers are: address 0 mark high byte, 1 mark low byte, 2 space high byte, 3 space low byte. Address 4 is control/status: bit 0 run, bit 1 request-enable, bit 2 DMA mode, and bit 7 the read-only flag. The data bytes read back what was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one access per clock |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| dma_done | input | 1 | Transfer-done pulse, clears the flag in DMA mode |
| mod_out | output | 1 | Modulated output, high during mark |
| irq | output | 1 | Interrupt request |
| dma_req | output | 1 | DMA request |

## Verification
The pattern is tried with a short cycle (mark 2, space 3) and a long one (16 and 16). The short cycle shows off-by-one errors in interval lengths and in reload timing. The long one leaves time for clear sequences between boundaries. Mid-cycle writes show whether buffered values leak into the running cycle, and toggling the run bit off then on inside a cycle shows a spurious restart flag. A dma_done pulse placed on the exact boundary clock tells set-priority apart from clear-priority, and a disarming access between the status read and the low-byte access tells a true two-step clear from a single-access clear.

// File: rtl/msm_pkg.sv
package msm_pkg;
  typedef enum logic {PH_MARK = 1'b0, PH_SPACE = 1'b1} msm_phase_e;

  localparam int unsigned ADDR_MARK_HI  = 0;
  localparam int unsigned ADDR_MARK_LO  = 1;
  localparam int unsigned ADDR_SPACE_HI = 2;
  localparam int unsigned ADDR_SPACE_LO = 3;
  localparam int unsigned ADDR_CTRL     = 4;

  localparam int unsigned CTRL_RUN_BIT = 0;
  localparam int unsigned CTRL_IE_BIT  = 1;
  localparam int unsigned CTRL_DMA_BIT = 2;
  localparam int unsigned CTRL_BITS    = 3;
  localparam int unsigned NUM_DATA     = 4;
endpackage

// File: rtl/msm_regs.sv
module msm_regs
  import msm_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel,
  input  logic            wr,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wdata,
  input  logic            flag,
  output logic [DW-1:0]   rdata,
  output logic [2*DW-1:0] mark_buf,
  output logic [2*DW-1:0] space_buf,
  output logic            run_en,
  output logic            irq_en,
  output logic            dma_mode,
  output logic            stat_rd,
  output logic            lo_acc,
  output logic            other_acc
);
  localparam int FLAG_BIT = DW - 1;

  logic [DW-1:0]        data_q [NUM_DATA];
  logic [CTRL_BITS-1:0] ctrl_q;

  function automatic logic addr_is(input logic [AW-1:0] a, input int unsigned idx);
    return a == AW'(idx);
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_DATA; i++) data_q[i] <= '0;
      ctrl_q <= '0;
    end else if (sel && wr) begin
      for (int i = 0; i < NUM_DATA; i++)
        if (addr_is(addr, i)) data_q[i] <= wdata;
      if (addr_is(addr, ADDR_CTRL)) ctrl_q <= wdata[CTRL_BITS-1:0];
    end
  end

  assign mark_buf  = {data_q[ADDR_MARK_HI],  data_q[ADDR_MARK_LO]};
  assign space_buf = {data_q[ADDR_SPACE_HI], data_q[ADDR_SPACE_LO]};
  assign run_en    = ctrl_q[CTRL_RUN_BIT];
  assign irq_en    = ctrl_q[CTRL_IE_BIT];
  assign dma_mode  = ctrl_q[CTRL_DMA_BIT];

  assign stat_rd   = sel && !wr && addr_is(addr, ADDR_CTRL);
  assign lo_acc    = sel && (addr_is(addr, ADDR_MARK_LO) || addr_is(addr, ADDR_SPACE_LO));
  assign other_acc = sel && !stat_rd;

  always_comb begin
    rdata = '0;
    if (addr_is(addr, ADDR_CTRL)) begin
      rdata[CTRL_BITS-1:0] = ctrl_q;
      rdata[FLAG_BIT]      = flag;
    end else begin
      for (int i = 0; i < NUM_DATA; i++)
        if (addr_is(addr, i)) rdata = data_q[i];
    end
  end

  // R11
  ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && addr_is(addr, ADDR_CTRL)) |=> (run_en == $past(wdata[CTRL_RUN_BIT])));
endmodule

// File: rtl/msm_engine.sv
module msm_engine
  import msm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run_en,
  input  logic [CW-1:0] mark_buf,
  input  logic [CW-1:0] space_buf,
  output logic          mod_out,
  output logic          eoc_evt
);
  logic          active;
  msm_phase_e    phase;
  logic [CW-1:0] mark_cnt;
  logic [CW-1:0] space_cnt;
  logic          start_evt;
  logic          boundary;

  function automatic logic [CW-1:0] count_down(input logic [CW-1:0] v);
    return v - CW'(1);
  endfunction

  function automatic logic at_zero(input logic [CW-1:0] v);
    return v == '0;
  endfunction

  assign start_evt = !active && run_en;
  assign boundary  = active && (phase == PH_SPACE) && at_zero(space_cnt);
  assign eoc_evt   = start_evt || (boundary && run_en);
  assign mod_out   = active && (phase == PH_MARK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      phase     <= PH_MARK;
      mark_cnt  <= '0;
      space_cnt <= '0;
    end else if (start_evt || (boundary && run_en)) begin
      active    <= 1'b1;
      phase     <= PH_MARK;
      mark_cnt  <= mark_buf;
      space_cnt <= space_buf;
    end else if (boundary) begin
      active <= 1'b0;
    end else if (active) begin
      if (phase == PH_MARK) begin
        if (at_zero(mark_cnt)) phase <= PH_SPACE;
        else                   mark_cnt <= count_down(mark_cnt);
      end else begin
        space_cnt <= count_down(space_cnt);
      end
    end
  end

  // R4
  eoc_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_evt |-> run_en);
  // R2
  start_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && run_en) |=> (active && mod_out));
  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && run_en) |=> (mark_cnt == $past(mark_buf) && space_cnt == $past(space_buf) && mod_out));
  // R4
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !run_en) |=> (!active && !mod_out));
endmodule

// File: rtl/msm_flag.sv
module msm_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic eoc_evt,
  input  logic stat_rd,
  input  logic lo_acc,
  input  logic other_acc,
  input  logic dma_mode,
  input  logic dma_done,
  input  logic irq_en,
  output logic flag,
  output logic irq,
  output logic dma_req
);
  logic armed;
  logic seq_clr;
  logic dma_clr;

  assign seq_clr = armed && lo_acc && !dma_mode;
  assign dma_clr = dma_mode && dma_done;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (eoc_evt)                 flag <= 1'b1;
      else if (seq_clr || dma_clr) flag <= 1'b0;
      if (stat_rd)        armed <= flag;
      else if (other_acc) armed <= 1'b0;
    end
  end

  assign irq     = flag && irq_en && !dma_mode;
  assign dma_req = flag && irq_en && dma_mode;

  // R10
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eoc_evt |=> flag);
  // R8
  dma_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dma_mode && dma_done && !eoc_evt) |=> !flag);
  // R7
  seq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && lo_acc && !dma_mode && !eoc_evt) |=> !flag);
  // R6
  req_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && irq_en) |-> (irq != dma_req));
endmodule

// File: rtl/mark_space_mod.sv
module mark_space_mod
  import msm_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          dma_done,
  output logic          mod_out,
  output logic          irq,
  output logic          dma_req
);
  localparam int CW = 2 * DW;

  logic [CW-1:0] mark_buf;
  logic [CW-1:0] space_buf;
  logic          run_en;
  logic          irq_en;
  logic          dma_mode;
  logic          stat_rd;
  logic          lo_acc;
  logic          other_acc;
  logic          flag;
  logic          eoc_evt;

  msm_regs #(.DW(DW), .AW(AW)) regs_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sel       (bus_sel),
    .wr        (bus_wr),
    .addr      (bus_addr),
    .wdata     (bus_wdata),
    .flag      (flag),
    .rdata     (bus_rdata),
    .mark_buf  (mark_buf),
    .space_buf (space_buf),
    .run_en    (run_en),
    .irq_en    (irq_en),
    .dma_mode  (dma_mode),
    .stat_rd   (stat_rd),
    .lo_acc    (lo_acc),
    .other_acc (other_acc)
  );

  msm_engine #(.CW(CW)) engine_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .run_en    (run_en),
    .mark_buf  (mark_buf),
    .space_buf (space_buf),
    .mod_out   (mod_out),
    .eoc_evt   (eoc_evt)
  );

  msm_flag flag_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .eoc_evt   (eoc_evt),
    .stat_rd   (stat_rd),
    .lo_acc    (lo_acc),
    .other_acc (other_acc),
    .dma_mode  (dma_mode),
    .dma_done  (dma_done),
    .irq_en    (irq_en),
    .flag      (flag),
    .irq       (irq),
    .dma_req   (dma_req)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (!mod_out && !irq && !dma_req));
endmodule

// File: tb/mark_space_mod_tb_top.sv
`timescale 1ns/100ps
module mark_space_mod_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0;
  logic       bus_wr = 1'b0;
  logic [2:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       dma_done = 1'b0;
  logic       mod_out, irq, dma_req;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mark_space_mod dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dma_done(dma_done), .mod_out(mod_out), .irq(irq), .dma_req(dma_req)
  );

  // Reference model: position within the cycle, latched lengths
  int m_bytes [4];
  int m_ctrl;
  bit m_flag, m_armed, m_active;
  int m_pos, m_lm, m_ls;

  function automatic int mk_mark();  return m_bytes[0] * 256 + m_bytes[1]; endfunction
  function automatic int mk_space(); return m_bytes[2] * 256 + m_bytes[3]; endfunction
  function automatic int cyc_len(input int mk, input int sp); return mk + sp + 2; endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_bytes[i]) m_bytes[i] = 0;
      m_ctrl = 0; m_flag = 0; m_armed = 0; m_active = 0;
      m_pos = 0; m_lm = 0; m_ls = 0;
    end else begin
      bit run, dma, set, clr;
      run = m_ctrl[0]; dma = m_ctrl[2]; set = 0; clr = 0;
      if (!m_active) begin
        if (run) begin m_active = 1; m_pos = 0; m_lm = mk_mark(); m_ls = mk_space(); set = 1; end
      end else begin
        m_pos++;
        if (m_pos == cyc_len(m_lm, m_ls)) begin
          if (run) begin m_pos = 0; m_lm = mk_mark(); m_ls = mk_space(); set = 1; end
          else m_active = 0;
        end
      end
      if (bus_sel && !bus_wr && bus_addr == 4) m_armed = m_flag;
      else if (bus_sel) begin
        if (m_armed && !dma && (bus_addr == 1 || bus_addr == 3)) clr = 1;
        m_armed = 0;
      end
      if (dma && dma_done) clr = 1;
      if (set) m_flag = 1; else if (clr) m_flag = 0;
      if (bus_sel && bus_wr) begin
        if (bus_addr < 4) m_bytes[bus_addr] = bus_wdata;
        else if (bus_addr == 4) m_ctrl = bus_wdata & 7;
      end
    end
  end

  function automatic int model_rdata(input int a);
    if (a < 4) return m_bytes[a];
    if (a == 4) return m_ctrl | (m_flag ? 128 : 0);
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle comparison of outputs against the model
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      bit e_mod, e_irq, e_dma;
      e_mod = m_active && (m_pos <= m_lm);
      e_irq = m_flag && m_ctrl[1] && !m_ctrl[2];
      e_dma = m_flag && m_ctrl[1] && m_ctrl[2];
      chk(mod_out == e_mod, "R2/R3/R4/R5/R9 mod_out", mod_out, e_mod);
      chk(irq == e_irq, "R6/R7/R10 irq", irq, e_irq);
      chk(dma_req == e_dma, "R6/R8/R10 dma_req", dma_req, e_dma);
    end
  end

  task automatic wr_reg(input int a, input int d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 3'(a); bus_wdata = 8'(d);
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_reg(input int a, input string tag);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = 3'(a);
    #1;
    chk(bus_rdata == 8'(model_rdata(a)), tag, bus_rdata, model_rdata(a));
    @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(!mod_out && !irq && !dma_req, "R1 outputs after reset", {mod_out, irq, dma_req}, 0);
    for (int a = 0; a < 5; a++) rd_reg(a, "R1/R11 reset readback");

    // Short cycle, interrupt mode
    wr_reg(0, 0); wr_reg(1, 2); wr_reg(2, 0); wr_reg(3, 3);
    for (int a = 0; a < 4; a++) rd_reg(a, "R11 data readback");
    wr_reg(4, 3);
    idle(2);
    chk(irq == 1, "R2 flag on start", irq, 1);
    idle(20);
    // Mid-cycle data writes apply at next boundary
    wr_reg(1, 5); wr_reg(3, 1);
    idle(25);
    // Long cycle for clear sequences
    wr_reg(1, 16); wr_reg(3, 16);
    idle(40);
    rd_reg(4, "R7 status read arms");
    rd_reg(1, "R7 low-byte access clears");
    idle(1);
    rd_reg(4, "R7 flag after clear");
    idle(40);
    rd_reg(4, "R7 status read arms again");
    wr_reg(0, 0);
    rd_reg(3, "R7 disarmed access keeps flag");
    rd_reg(4, "R7 flag kept");
    rd_reg(3, "R7 second arm clears");
    idle(3);
    // DMA mode
    wr_reg(4, 7);
    idle(40);
    rd_reg(4, "R8 status read in DMA mode");
    rd_reg(1, "R8 access does not clear");
    @(negedge clk); dma_done = 1;
    @(negedge clk); dma_done = 0;
    chk(dma_req == 0, "R8 dma_done clears", dma_req, 0);
    // dma_done on the boundary edge: set wins
    do @(negedge clk); while (!(m_active && m_pos == cyc_len(m_lm, m_ls) - 1));
    dma_done = 1;
    @(negedge clk); dma_done = 0;
    chk(dma_req == 1, "R10 set beats clear", dma_req, 1);
    @(negedge clk); dma_done = 1;
    @(negedge clk); dma_done = 0;
    // Run off then on inside a cycle
    idle(5);
    wr_reg(4, 6);
    wr_reg(4, 7);
    chk(dma_req == 0, "R5 no flag at re-enable", dma_req, 0);
    idle(40);
    // Disable and let the last cycle finish
    wr_reg(4, 6);
    idle(45);
    chk(mod_out == 0, "R4 idle after final cycle", mod_out, 0);
    rd_reg(4, "R4 no flag at final boundary");
    idle(4);
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 20000, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule